// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the bus-facing register file of an interrupt routing controller. Software reaches the state through two locations. It first writes a register number into a select register. It then reads or writes a data window that maps onto whichever internal register the select names. That register can be a fixed version word, a 4-bit controller identifier (visible under two select values), or one 32-bit half of a per-pin 64-bit routing entry.

The complete routing table leaves the block on a flat output bus, so that delivery logic elsewhere can use it directly. Each entry write raises a one-cycle strobe for its pin. When a write flips a pin's mask bit, a separate one-cycle notification carries the pin index and the new mask value. Delivery and end-of-interrupt handling live outside this block.

Top module: `irq_route_window`

## Requirements
- R1: After reset the select register reads 0 and the identifier reads 0. Every routing entry holds only its mask bit (bit 16) set, so the low half reads 0x0001_0000 and the high half reads 0.
- R2: Only address bits 7:0 are decoded, so the higher bits alias. Offset 0x00 is the 8-bit select register (read back zero-extended). Offset 0x10 is the data window. Any other offset reads 0, and writes to it change nothing.
- R3: With select 0x01, the window reads PINS−1 in bits 23:16 and the VERSION parameter in bits 7:0, with all other bits 0. Writes through the window to this select are ignored.
- R4: With select 0x00, a window write stores data bits 27:24 as the identifier. Window reads with select 0x00 or 0x02 return the identifier in bits 27:24 and 0 elsewhere. A window write with select 0x02 is ignored.
- R5: For select ≥ 0x10, the pin is (select − 0x10) >> 1. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. A write to one half leaves the other half unchanged.
- R6: A window write whose pin index is ≥ PINS changes no entry and raises no strobe. A window read there returns 0.
- R7: A low-half write always leaves the entry's remote-pending bit (bit 14) at 0, whatever the written data holds there.
- R8: An entry write sets bit i of `entry_wr_pulse` (i = pin) for exactly the one cycle after the write edge. At most one bit is ever set.
- R9: When an entry write changes bit 16 (mask), `mask_chg_valid` is high in that same cycle, with `mask_chg_pin` = pin and `mask_chg_value` = new mask. A write that keeps the mask raises no notification.
- R10: `entry_table[64*i +: 64]` carries entry i and shows a write from the cycle after the write edge.
- R11: Window reads with selects 0x03–0x0F return 0, and window writes with those selects change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits 7:0 decoded |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| entry_table | output | PINS*64 | All routing entries, pin 0 at the bottom |
| entry_wr_pulse | output | PINS | One-cycle strobe per written entry |
| mask_chg_valid | output | 1 | A mask bit changed on the last write |
| mask_chg_pin | output | IDX_W | Pin whose mask changed |
| mask_chg_value | output | 1 | New mask value |

## Verification
A wrong select register or a bad pin-index decode sends the next window access to another register. The very next window read shows a value from a different entry or field, and a write shows a strobe on the wrong pin one cycle after the edge. A stale remote-pending bit or a lost half-write appears both in the next window read and in `entry_table` one cycle after the write. A missed or spurious mask notification shows up on the `mask_chg_*` outputs in that same cycle.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
   localparam int DATA_W     = 32;
   localparam int ENTRY_W    = 64;
   localparam int SEL_W      = 8;
   localparam int ID_W       = 4;
   localparam int ID_LSB     = 24;
   localparam int BIT_REMOTE = 14;
   localparam int BIT_MASK   = 16;

   localparam logic [7:0] OFS_SELECT = 8'h00;
   localparam logic [7:0] OFS_WINDOW = 8'h10;

   localparam logic [SEL_W-1:0] SEL_IDENT   = 8'h00;
   localparam logic [SEL_W-1:0] SEL_VERSION = 8'h01;
   localparam logic [SEL_W-1:0] SEL_ARB     = 8'h02;
   localparam logic [SEL_W-1:0] SEL_TABLE   = 8'h10;

   localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h1 << BIT_MASK;

   typedef enum logic [2:0] {
      K_NONE,
      K_VERSION,
      K_IDENT,
      K_ARB,
      K_ENTRY
   } win_kind_t;
endpackage

// File: rtl/irqw_sel_decode.sv
module irqw_sel_decode
   import irqw_pkg::*;
#(
   parameter int PINS  = 24,
   parameter int IDX_W = 5
) (
   input  logic [SEL_W-1:0] sel,
   output win_kind_t        kind,
   output logic [IDX_W-1:0] pin_idx,
   output logic             hi_half,
   output logic             in_range
);
   logic [SEL_W-1:0] off;
   logic [SEL_W-2:0] idx_full;

   always_comb begin
      off      = sel - SEL_TABLE;
      idx_full = off[SEL_W-1:1];
      hi_half  = off[0];
      pin_idx  = idx_full[IDX_W-1:0];
      in_range = (sel >= SEL_TABLE) && (int'(idx_full) < PINS);
      if (sel >= SEL_TABLE)        kind = K_ENTRY;
      else if (sel == SEL_IDENT)   kind = K_IDENT;
      else if (sel == SEL_VERSION) kind = K_VERSION;
      else if (sel == SEL_ARB)     kind = K_ARB;
      else                         kind = K_NONE;
   end
endmodule

// File: rtl/irqw_entry.sv
module irqw_entry
   import irqw_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_lo,
   input  logic               wr_hi,
   input  logic [DATA_W-1:0]  wdata,
   output logic [ENTRY_W-1:0] entry_q,
   output logic               wr_pulse,
   output logic               mask_chg,
   output logic               mask_now
);
   logic [ENTRY_W-1:0] entry_d;
   logic [DATA_W-1:0]  lo_clean;

   always_comb begin
      lo_clean             = wdata;
      lo_clean[BIT_REMOTE] = 1'b0;
      entry_d              = entry_q;
      if (wr_lo) entry_d[DATA_W-1:0]       = lo_clean;
      if (wr_hi) entry_d[ENTRY_W-1:DATA_W] = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         entry_q  <= ENTRY_RST;
         wr_pulse <= 1'b0;
         mask_chg <= 1'b0;
      end else begin
         entry_q  <= entry_d;
         wr_pulse <= wr_lo | wr_hi;
         mask_chg <= (wr_lo | wr_hi) && (entry_d[BIT_MASK] != entry_q[BIT_MASK]);
      end
   end

   assign mask_now = entry_q[BIT_MASK];

   AST_REMOTE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> !entry_q[BIT_REMOTE]); // R7
   AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> entry_q[DATA_W-1:0] == $past(entry_q[DATA_W-1:0])); // R5
   AST_MASK_FLAG_REAL: assert property (@(posedge clk) disable iff (!rst_n)
      mask_chg |-> entry_q[BIT_MASK] != $past(entry_q[BIT_MASK])); // R9
endmodule

// File: rtl/irqw_read_mux.sv
module irqw_read_mux
   import irqw_pkg::*;
#(
   parameter int         PINS    = 24,
   parameter int         IDX_W   = 5,
   parameter logic [7:0] VERSION = 8'h11
) (
   input  logic [7:0]          addr_lo,
   input  logic [SEL_W-1:0]    sel,
   input  win_kind_t           kind,
   input  logic [IDX_W-1:0]    pin_idx,
   input  logic                hi_half,
   input  logic                in_range,
   input  logic [ID_W-1:0]     ident,
   input  logic [PINS*ENTRY_W-1:0] table_flat,
   output logic [DATA_W-1:0]   rdata
);
   localparam logic [7:0] MAX_PIN = 8'(PINS - 1);

   logic [DATA_W-1:0]  win;
   logic [ENTRY_W-1:0] ent;

   always_comb begin
      ent = '0;
      if (in_range) ent = table_flat[int'(pin_idx)*ENTRY_W +: ENTRY_W];
      win = '0;
      unique case (kind)
         K_VERSION:     win = {8'h00, MAX_PIN, 8'h00, VERSION};
         K_IDENT, K_ARB: win[ID_LSB +: ID_W] = ident;
         K_ENTRY:       win = hi_half ? ent[ENTRY_W-1:DATA_W] : ent[DATA_W-1:0];
         default:       win = '0;
      endcase
      if (addr_lo == OFS_SELECT)      rdata = {{(DATA_W-SEL_W){1'b0}}, sel};
      else if (addr_lo == OFS_WINDOW) rdata = win;
      else                            rdata = '0;
   end
endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
   import irqw_pkg::*;
#(
   parameter int         PINS    = 24,
   parameter int         ADDR_W  = 12,
   parameter logic [7:0] VERSION = 8'h11,
   localparam int        IDX_W   = (PINS > 1) ? $clog2(PINS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_we,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic [PINS*ENTRY_W-1:0]  entry_table,
   output logic [PINS-1:0]          entry_wr_pulse,
   output logic                     mask_chg_valid,
   output logic [IDX_W-1:0]         mask_chg_pin,
   output logic                     mask_chg_value
);
   generate
      if (PINS < 1 || PINS > 120) begin : g_bad_pins
         $error("PINS must lie in 1..120 to fit an 8-bit select");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be at least 8");
      end
   endgenerate

   logic [7:0]       addr_lo;
   logic             addr_unused;
   logic [SEL_W-1:0] sel_q;
   logic [ID_W-1:0]  id_q;
   win_kind_t        kind;
   logic [IDX_W-1:0] pin_idx;
   logic             hi_half, in_range;
   logic             hit_sel, hit_win, win_wr, ent_wr;
   logic [PINS-1:0]  chg_vec, mask_vec;

   assign addr_lo     = bus_addr[7:0];
   assign addr_unused = ^bus_addr;
   assign hit_sel     = (addr_lo == OFS_SELECT);
   assign hit_win     = (addr_lo == OFS_WINDOW);
   assign win_wr      = bus_we && hit_win;
   assign ent_wr      = win_wr && (kind == K_ENTRY) && in_range;

   irqw_sel_decode #(.PINS(PINS), .IDX_W(IDX_W)) u_dec (
      .sel(sel_q), .kind(kind), .pin_idx(pin_idx),
      .hi_half(hi_half), .in_range(in_range)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         if (bus_we && hit_sel) sel_q <= bus_wdata[SEL_W-1:0];
         if (win_wr && kind == K_IDENT) id_q <= bus_wdata[ID_LSB +: ID_W];
      end
   end

   generate
      for (genvar i = 0; i < PINS; i++) begin : g_pin
         logic sel_me;
         assign sel_me = ent_wr && (int'(pin_idx) == i);
         irqw_entry u_ent (
            .clk(clk), .rst_n(rst_n),
            .wr_lo(sel_me && !hi_half), .wr_hi(sel_me && hi_half),
            .wdata(bus_wdata),
            .entry_q(entry_table[i*ENTRY_W +: ENTRY_W]),
            .wr_pulse(entry_wr_pulse[i]),
            .mask_chg(chg_vec[i]), .mask_now(mask_vec[i])
         );
      end
   endgenerate

   always_comb begin
      mask_chg_pin   = '0;
      mask_chg_value = 1'b0;
      for (int i = 0; i < PINS; i++) begin
         if (chg_vec[i]) begin
            mask_chg_pin   = IDX_W'(i);
            mask_chg_value = mask_vec[i];
         end
      end
   end
   assign mask_chg_valid = |chg_vec;

   irqw_read_mux #(.PINS(PINS), .IDX_W(IDX_W), .VERSION(VERSION)) u_rd (
      .addr_lo(addr_lo), .sel(sel_q), .kind(kind), .pin_idx(pin_idx),
      .hi_half(hi_half), .in_range(in_range), .ident(id_q),
      .table_flat(entry_table), .rdata(bus_rdata)
   );

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(entry_wr_pulse)); // R8
   AST_OOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && kind == K_ENTRY && !in_range) |=> entry_wr_pulse == '0); // R6
   AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_wr && kind == K_IDENT) |=> $stable(id_q)); // R4
   AST_MASK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mask_chg_valid |-> entry_wr_pulse != '0); // R9
   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && hit_sel) |=> $stable(sel_q)); // R2
endmodule

// File: tb/irq_route_window_test.sv
module irq_route_window_test;
   localparam int PINS   = 24;
   localparam int ADDR_W = 12;
   localparam int IDX_W  = 5;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [ADDR_W-1:0]    bus_addr = '0;
   logic                 bus_we = 1'b0;
   logic [31:0]          bus_wdata = '0;
   logic [31:0]          bus_rdata;
   logic [PINS*64-1:0]   entry_table;
   logic [PINS-1:0]      entry_wr_pulse;
   logic                 mask_chg_valid;
   logic [IDX_W-1:0]     mask_chg_pin;
   logic                 mask_chg_value;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_route_window #(.PINS(PINS), .ADDR_W(ADDR_W), .VERSION(8'h11)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entry_table(entry_table),
      .entry_wr_pulse(entry_wr_pulse), .mask_chg_valid(mask_chg_valid),
      .mask_chg_pin(mask_chg_pin), .mask_chg_value(mask_chg_value)
   );

   // {tag[7:0], we, addr[7:0], data[31:0], expected read[31:0]}
   localparam int NV = 32;
   localparam logic [80:0] VEC [NV] = '{
      {8'd3, 1'b1, 8'h00, 32'h0000_0001, 32'h0},            // R3 select version
      {8'd3, 1'b0, 8'h10, 32'h0,         32'h0017_0011},    // R3
      {8'd3, 1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0},            // R3 write ignored
      {8'd3, 1'b0, 8'h10, 32'h0,         32'h0017_0011},    // R3
      {8'd4, 1'b1, 8'h00, 32'h0000_0000, 32'h0},            // R4
      {8'd4, 1'b1, 8'h10, 32'hA500_0000, 32'h0},            // R4 id = 5
      {8'd4, 1'b0, 8'h10, 32'h0,         32'h0500_0000},    // R4
      {8'd4, 1'b1, 8'h00, 32'h0000_0002, 32'h0},            // R4 arbitration
      {8'd4, 1'b0, 8'h10, 32'h0,         32'h0500_0000},    // R4
      {8'd4, 1'b1, 8'h10, 32'h0F00_0000, 32'h0},            // R4 ignored
      {8'd4, 1'b0, 8'h10, 32'h0,         32'h0500_0000},    // R4
      {8'd4, 1'b1, 8'h00, 32'h0000_0000, 32'h0},            // R4
      {8'd4, 1'b0, 8'h10, 32'h0,         32'h0500_0000},    // R4
      {8'd7, 1'b1, 8'h00, 32'h0000_0010, 32'h0},            // R7 pin 0 low
      {8'd7, 1'b1, 8'h10, 32'h0000_C031, 32'h0},            // R7 remote set in data
      {8'd7, 1'b0, 8'h10, 32'h0,         32'h0000_8031},    // R7 remote cleared
      {8'd5, 1'b1, 8'h00, 32'h0000_0011, 32'h0},            // R5 pin 0 high
      {8'd5, 1'b1, 8'h10, 32'hAB00_0000, 32'h0},            // R5
      {8'd5, 1'b0, 8'h10, 32'h0,         32'hAB00_0000},    // R5
      {8'd5, 1'b1, 8'h00, 32'h0000_003F, 32'h0},            // R5 pin 23 high
      {8'd5, 1'b1, 8'h10, 32'h1234_5678, 32'h0},            // R5
      {8'd5, 1'b0, 8'h10, 32'h0,         32'h1234_5678},    // R5
      {8'd6, 1'b1, 8'h00, 32'h0000_0040, 32'h0},            // R6 pin 24
      {8'd6, 1'b1, 8'h10, 32'hDEAD_BEEF, 32'h0},            // R6
      {8'd6, 1'b0, 8'h10, 32'h0,         32'h0},            // R6
      {8'd11, 1'b1, 8'h00, 32'h0000_0005, 32'h0},           // R11
      {8'd11, 1'b0, 8'h10, 32'h0,        32'h0},            // R11
      {8'd11, 1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0},           // R11
      {8'd2, 1'b0, 8'h20, 32'h0,         32'h0},            // R2 other offset
      {8'd2, 1'b0, 8'h00, 32'h0,         32'h0000_0005},    // R2
      {8'd2, 1'b1, 8'h04, 32'h0000_FFFF, 32'h0},            // R2 ignored
      {8'd2, 1'b0, 8'h00, 32'h0,         32'h0000_0005}     // R2
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input string req, input logic [31:0] exp);
      bus_we = 1'b0; bus_addr = a;
      #1;
      check(req, {32'h0, bus_rdata}, {32'h0, exp});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(12'h000, "R1", 32'h0);
      rd(12'h010, "R1", 32'h0);
      begin
         logic [63:0] exp_ent;
         logic        ok = 1'b1;
         exp_ent = 64'h0000_0000_0001_0000;
         for (int i = 0; i < PINS; i++)
            if (entry_table[i*64 +: 64] !== exp_ent) ok = 1'b0;
         check("R1", {63'h0, ok}, 64'h1);
      end
      wr(12'h000, 32'h3E);
      rd(12'h010, "R1", 32'h0001_0000);
      wr(12'h000, 32'h3F);
      rd(12'h010, "R1", 32'h0);

      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = $sformatf("R%0d", VEC[v][80:73]);
         if (VEC[v][72]) wr({4'h0, VEC[v][71:64]}, VEC[v][63:32]);
         else            rd({4'h0, VEC[v][71:64]}, tag, VEC[v][31:0]);
      end

      rd(12'h100, "R2", 32'h5);                       // R2 alias of select
      check("R10", entry_table[23*64 +: 64], 64'h1234_5678_0001_0000);
      check("R10", entry_table[0 +: 64], 64'hAB00_0000_0000_8031);

      // R6: out-of-range write strobes nothing
      wr(12'h000, 32'h41);
      wr(12'h010, 32'hFFFF_FFFF);
      check("R6", {40'h0, entry_wr_pulse}, 64'h0);
      check("R6", entry_table[23*64 +: 64], 64'h1234_5678_0001_0000);

      // R8 / R9 on pin 1 low half
      wr(12'h000, 32'h12);
      wr(12'h010, 32'h0000_0040);
      check("R8", {40'h0, entry_wr_pulse}, 64'h2);
      check("R9", {57'h0, mask_chg_valid, mask_chg_pin, mask_chg_value}, {57'h0, 1'b1, 5'd1, 1'b0});
      check("R10", entry_table[64 +: 64], 64'h0000_0000_0000_0040);
      @(negedge clk);
      check("R8", {40'h0, entry_wr_pulse}, 64'h0);
      check("R9", {63'h0, mask_chg_valid}, 64'h0);
      wr(12'h010, 32'h0000_0041);
      check("R8", {40'h0, entry_wr_pulse}, 64'h2);
      check("R9", {63'h0, mask_chg_valid}, 64'h0);
      wr(12'h010, 32'h0001_0041);
      check("R9", {57'h0, mask_chg_valid, mask_chg_pin, mask_chg_value}, {57'h0, 1'b1, 5'd1, 1'b1});
      // R5: high half of pin 22 leaves its low half
      wr(12'h000, 32'h3D);
      wr(12'h010, 32'h7700_0000);
      check("R5", entry_table[22*64 +: 64], 64'h7700_0000_0001_0000);
      check("R9", {63'h0, mask_chg_valid}, 64'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule